// File: doc/BRIEF.md
# Memory Response Ordering Unit

This block sits between an instruction issue stage and the memory system of a compute pipeline. Requests arrive on a valid/ready issue port, each carrying a sequence number, a kind (load, store, atomic or fence) and nothing else: addresses and data travel elsewhere. The block meters loads and stores against two separate credit pools and passes accepted requests straight on to a downstream valid/ready port. Responses coming back from memory are collected. At most one finished request per cycle is offered to the register writeback stage on a valid/ready completion port, which carries the sequence number and kind.

A static mode pin selects the return policy. In ordered mode a reorder buffer slot, indexed by sequence number modulo the depth, is reserved at issue time and completions leave in strict sequence order. In unordered mode responses land in a load return FIFO and a store return FIFO, and the load side is always served first. After each completion the writeback bus is held busy for a latency count supplied with the response.

Back-pressure: `iss_ready` is low whenever the downstream port is not ready, the needed credit pool is exhausted, or (ordered mode) the reorder slot for that sequence number is still occupied. Because only the head request is visible, such a stall holds back everything behind it. `rsp_ready` is always high; a response that cannot be stored raises an error pulse instead. `cmp_valid` may fall only through the block's own gating, and a completion retires on `cmp_valid && cmp_ready`.

Top module: `mem_return_orderer`

## Requirements
- R1: Loads and atomics draw from one pool and stores from another, each holding at most DEPTH outstanding requests; a store can issue while the load pool is exhausted, and the reverse also holds.
- R2: When the head request needs an exhausted pool, `iss_ready` and `req_valid` are both low in that cycle. Fences (kind 3) use no credit and are never held back by credits.
- R3: In ordered mode a fence takes no reorder slot and never produces a completion; non-fence requests carry consecutive sequence numbers starting from 0 after reset.
- R4: In ordered mode, a response whose sequence number matches no outstanding, not-yet-answered entry raises `err_orphan` combinationally in the cycle it is presented.
- R5: In ordered mode completions appear strictly in sequence-number order; an answered younger request is not offered while an older one is unanswered.
- R6: In unordered mode, while the load return FIFO holds an entry, no store completion is offered, even when the load is blocked.
- R7: In unordered mode, a response arriving while its target return FIFO (loads and atomics to the load FIFO, stores to the store FIFO) already holds DEPTH entries raises `err_overflow` and is dropped.
- R8: A load (kind 0) or atomic (kind 2) completion is offered only while `reg_wr_ready` is high; a store (kind 1) completion ignores `reg_wr_ready`.
- R9: After a completion that retires with latency L, `cmp_valid` stays low for the next L cycles.
- R10: Retiring a completion returns one credit to the pool of its kind, so a request stalled on that pool can issue in the following cycle.
- R11: After reset both pools are empty, `cmp_valid` and both error outputs are low, and `iss_ready` follows `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ooo_mode | input | 1 | 0 ordered return, 1 unordered return; static between resets |
| iss_valid | input | 1 | Issue request valid |
| iss_ready | output | 1 | Issue request accepted |
| iss_seq | input | SEQ_W | Request sequence number |
| iss_kind | input | 2 | 0 load, 1 store, 2 atomic, 3 fence |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream can accept |
| req_seq | output | SEQ_W | Downstream sequence number |
| req_kind | output | 2 | Downstream kind |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Always high |
| rsp_seq | input | SEQ_W | Response sequence number |
| rsp_kind | input | 2 | Response kind |
| rsp_lat | input | LAT_W | Writeback busy cycles for this response |
| cmp_valid | output | 1 | Completion offered |
| cmp_ready | input | 1 | Writeback takes the completion |
| cmp_seq | output | SEQ_W | Completed sequence number |
| cmp_kind | output | 2 | Completed kind |
| reg_wr_ready | input | 1 | Register file can accept a write |
| err_orphan | output | 1 | Ordered-mode response without an entry |
| err_overflow | output | 1 | Unordered-mode response into a full FIFO |

## Verification
Issue acceptance and both error flags are combinational, so the bench drives a stimulus just after a falling edge and reads those outputs a moment later in the same cycle. A response becomes visible as a completion one cycle after the edge that captures it, and a retirement with latency L hides `cmp_valid` for exactly L further falling-edge samples before the next one is taken. Each task therefore samples at a falling edge counted from the rising edge that registers the stimulus, never at the rising edge itself.

// File: rtl/mro_pkg.sv
package mro_pkg;
  localparam logic [1:0] KIND_LOAD   = 2'd0;
  localparam logic [1:0] KIND_STORE  = 2'd1;
  localparam logic [1:0] KIND_ATOMIC = 2'd2;
  localparam logic [1:0] KIND_FENCE  = 2'd3;

  function automatic logic uses_ld_pool(input logic [1:0] k);
    return (k == KIND_LOAD) || (k == KIND_ATOMIC);
  endfunction
endpackage

// File: rtl/mro_credit.sv
module mro_credit #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    take,     // [0] load pool, [1] store pool
  input  logic [1:0]    give,
  output logic [1:0]    at_cap,
  output logic [CW-1:0] ld_cnt,
  output logic [CW-1:0] st_cnt
);
  logic [CW-1:0] cnt [2];

  for (genvar g = 0; g < 2; g++) begin : g_pool
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (take[g] && !(give[g] && cnt[g] != '0)) begin
        cnt[g] <= cnt[g] + CW'(1);
      end else if (!take[g] && give[g] && cnt[g] != '0) begin
        cnt[g] <= cnt[g] - CW'(1);
      end
    end
    assign at_cap[g] = (cnt[g] >= CW'(DEPTH));
  end

  assign ld_cnt = cnt[0];
  assign st_cnt = cnt[1];
endmodule

// File: rtl/mro_retq.sv
module mro_retq #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         empty,
  output logic         full,
  output logic [W-1:0] head
);
  logic [W-1:0] mem [DEPTH];
  logic [IW:0]  wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[IW] != rp[IW]) && (wp[IW-1:0] == rp[IW-1:0]);
  assign head  = mem[rp[IW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) begin
        mem[wp[IW-1:0]] <= push_data;
        wp <= wp + 1'b1;
      end
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/mro_rob.sv
module mro_rob #(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEQ_W-1:0] q_seq,
  output logic             q_free,
  input  logic             alloc,
  input  logic [1:0]       alloc_kind,
  input  logic             mark,
  input  logic [SEQ_W-1:0] mark_seq,
  input  logic [LAT_W-1:0] mark_lat,
  output logic             mark_hit,
  input  logic             retire,
  output logic             head_ok,
  output logic [SEQ_W-1:0] head_seq,
  output logic [1:0]       head_kind,
  output logic [LAT_W-1:0] head_lat
);
  logic [DEPTH-1:0] vld, done;
  logic [SEQ_W-1:0] e_seq  [DEPTH];
  logic [1:0]       e_kind [DEPTH];
  logic [LAT_W-1:0] e_lat  [DEPTH];
  logic [SEQ_W-1:0] hd;

  wire [IW-1:0] qi = q_seq[IW-1:0];
  wire [IW-1:0] mi = mark_seq[IW-1:0];
  wire [IW-1:0] hi = hd[IW-1:0];

  assign q_free    = !vld[qi];
  assign mark_hit  = vld[mi] && !done[mi] && (e_seq[mi] == mark_seq);
  assign head_ok   = vld[hi] && done[hi] && (e_seq[hi] == hd);
  assign head_seq  = hd;
  assign head_kind = e_kind[hi];
  assign head_lat  = e_lat[hi];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      done <= '0;
      hd   <= '0;
    end else begin
      if (alloc) begin
        vld[qi]    <= 1'b1;
        done[qi]   <= 1'b0;
        e_seq[qi]  <= q_seq;
        e_kind[qi] <= alloc_kind;
      end
      if (mark && mark_hit) begin
        done[mi]  <= 1'b1;
        e_lat[mi] <= mark_lat;
      end
      if (retire && head_ok) begin
        vld[hi] <= 1'b0;
        hd      <= hd + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_return_orderer.sv
module mem_return_orderer
  import mro_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ooo_mode,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [SEQ_W-1:0] iss_seq,
  input  logic [1:0]       iss_kind,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [SEQ_W-1:0] req_seq,
  output logic [1:0]       req_kind,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [SEQ_W-1:0] rsp_seq,
  input  logic [1:0]       rsp_kind,
  input  logic [LAT_W-1:0] rsp_lat,
  output logic             cmp_valid,
  input  logic             cmp_ready,
  output logic [SEQ_W-1:0] cmp_seq,
  output logic [1:0]       cmp_kind,
  input  logic             reg_wr_ready,
  output logic             err_orphan,
  output logic             err_overflow
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = SEQ_W + 2 + LAT_W;

  // ---------------- issue path ----------------
  logic [1:0]    at_cap, take, give;
  logic [CW-1:0] ld_cnt, st_cnt;
  logic          rob_free, go, fire;
  wire           iss_fence = (iss_kind == KIND_FENCE);
  wire           iss_ld    = uses_ld_pool(iss_kind);
  wire           iss_st    = (iss_kind == KIND_STORE);

  assign go        = !(iss_ld && at_cap[0]) && !(iss_st && at_cap[1])
                     && (ooo_mode || iss_fence || rob_free);
  assign iss_ready = req_ready && go;
  assign req_valid = iss_valid && go;
  assign req_seq   = iss_seq;
  assign req_kind  = iss_kind;
  assign fire      = iss_valid && iss_ready;
  assign take      = {fire && iss_st, fire && iss_ld};

  mro_credit #(.DEPTH(DEPTH)) u_credit (
    .clk(clk), .rst_n(rst_n), .take(take), .give(give),
    .at_cap(at_cap), .ld_cnt(ld_cnt), .st_cnt(st_cnt)
  );

  // ---------------- response path ----------------
  logic             rob_hit, rob_ok, retire;
  logic [SEQ_W-1:0] rob_seq;
  logic [1:0]       rob_kind;
  logic [LAT_W-1:0] rob_lat;
  wire              rsp_ld = uses_ld_pool(rsp_kind);

  assign rsp_ready  = 1'b1;
  assign err_orphan = rsp_valid && !ooo_mode && !rob_hit;

  mro_rob #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) u_rob (
    .clk(clk), .rst_n(rst_n),
    .q_seq(iss_seq), .q_free(rob_free),
    .alloc(fire && !ooo_mode && !iss_fence), .alloc_kind(iss_kind),
    .mark(rsp_valid && !ooo_mode), .mark_seq(rsp_seq), .mark_lat(rsp_lat),
    .mark_hit(rob_hit),
    .retire(retire && !ooo_mode),
    .head_ok(rob_ok), .head_seq(rob_seq), .head_kind(rob_kind), .head_lat(rob_lat)
  );

  // Return FIFOs: index 0 loads/atomics, index 1 stores
  logic [1:0]    q_push, q_pop, q_empty, q_full;
  logic [EW-1:0] q_head [2];
  wire  [EW-1:0] rsp_ent = {rsp_seq, rsp_kind, rsp_lat};

  assign q_push[0]    = rsp_valid && ooo_mode && rsp_ld && !q_full[0];
  assign q_push[1]    = rsp_valid && ooo_mode && !rsp_ld && !q_full[1];
  assign err_overflow = rsp_valid && ooo_mode && (rsp_ld ? q_full[0] : q_full[1]);

  for (genvar g = 0; g < 2; g++) begin : g_retq
    mro_retq #(.DEPTH(DEPTH), .W(EW)) u_q (
      .clk(clk), .rst_n(rst_n), .push(q_push[g]), .push_data(rsp_ent),
      .pop(q_pop[g]), .empty(q_empty[g]), .full(q_full[g]), .head(q_head[g])
    );
  end

  // ---------------- completion select ----------------
  logic             cand_v;
  logic [SEQ_W-1:0] cand_seq;
  logic [1:0]       cand_kind;
  logic [LAT_W-1:0] cand_lat;
  logic [LAT_W-1:0] busy_cnt;

  always_comb begin
    if (!ooo_mode) begin
      cand_v = rob_ok;
      {cand_seq, cand_kind, cand_lat} = {rob_seq, rob_kind, rob_lat};
    end else if (!q_empty[0]) begin
      cand_v = 1'b1;
      {cand_seq, cand_kind, cand_lat} = q_head[0];
    end else begin
      cand_v = !q_empty[1];
      {cand_seq, cand_kind, cand_lat} = q_head[1];
    end
  end

  wire cand_ld = uses_ld_pool(cand_kind);

  assign cmp_valid = cand_v && (busy_cnt == '0) && (!cand_ld || reg_wr_ready);
  assign cmp_seq   = cand_seq;
  assign cmp_kind  = cand_kind;
  assign retire    = cmp_valid && cmp_ready;
  assign q_pop     = {retire && ooo_mode && q_empty[0], retire && ooo_mode && !q_empty[0]};
  assign give      = {retire && (cand_kind == KIND_STORE), retire && cand_ld};

  always_ff @(posedge clk) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (retire)           busy_cnt <= cand_lat;
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - 1'b1;
  end
endmodule

// File: rtl/mro_checker.sv
module mro_checker
  import mro_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int SEQ_W = 8,
  parameter int LAT_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ooo_mode,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic [1:0]       iss_kind,
  input logic             cmp_valid,
  input logic             cmp_ready,
  input logic [SEQ_W-1:0] cmp_seq,
  input logic [1:0]       cmp_kind,
  input logic             reg_wr_ready,
  input logic [CW-1:0]    ld_cnt,
  input logic [CW-1:0]    st_cnt,
  input logic             ldq_empty,
  input logic [LAT_W-1:0] cand_lat
);
  logic [SEQ_W-1:0] exp_seq;
  always_ff @(posedge clk) begin
    if (!rst_n) exp_seq <= '0;
    else if (cmp_valid && cmp_ready) exp_seq <= exp_seq + 1'b1;
  end

  assert_credit_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_cnt <= CW'(DEPTH)) && (st_cnt <= CW'(DEPTH)));

  assert_stall_at_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && uses_ld_pool(iss_kind) && ld_cnt == CW'(DEPTH)) |-> !iss_ready);

  assert_fence_no_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && iss_kind == KIND_FENCE && !(cmp_valid && cmp_ready))
    |=> ($stable(ld_cnt) && $stable(st_cnt)));

  assert_seq_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ooo_mode && cmp_valid) |-> (cmp_seq == exp_seq));

  assert_load_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ooo_mode && cmp_valid && cmp_kind == KIND_STORE) |-> ldq_empty);

  assert_wr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && uses_ld_pool(cmp_kind)) |-> reg_wr_ready);

  assert_bus_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_ready && cand_lat != '0) |=> !cmp_valid);
endmodule

bind mem_return_orderer mro_checker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ooo_mode(ooo_mode),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_kind(iss_kind),
  .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_seq(cmp_seq), .cmp_kind(cmp_kind),
  .reg_wr_ready(reg_wr_ready), .ld_cnt(ld_cnt), .st_cnt(st_cnt),
  .ldq_empty(q_empty[0]), .cand_lat(cand_lat)
);

// File: tb/mem_return_orderer_tb.sv
`timescale 1ns/1ps
module mem_return_orderer_tb;
  localparam int SEQ_W = 8;
  localparam int LAT_W = 4;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, AT = 2'd2, FN = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ooo_mode = 1'b0;
  logic iss_valid = 1'b0, req_ready = 1'b1, rsp_valid = 1'b0;
  logic cmp_ready = 1'b0, reg_wr_ready = 1'b1;
  logic [SEQ_W-1:0] iss_seq = '0, rsp_seq = '0;
  logic [1:0] iss_kind = '0, rsp_kind = '0;
  logic [LAT_W-1:0] rsp_lat = '0;
  logic iss_ready, req_valid, rsp_ready, cmp_valid, err_orphan, err_overflow;
  logic [SEQ_W-1:0] req_seq, cmp_seq;
  logic [1:0] req_kind, cmp_kind;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mem_return_orderer #(.DEPTH(4), .SEQ_W(SEQ_W), .LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ooo_mode(ooo_mode),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_seq(iss_seq), .iss_kind(iss_kind),
    .req_valid(req_valid), .req_ready(req_ready), .req_seq(req_seq), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_seq(rsp_seq), .rsp_kind(rsp_kind),
    .rsp_lat(rsp_lat), .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_seq(cmp_seq),
    .cmp_kind(cmp_kind), .reg_wr_ready(reg_wr_ready),
    .err_orphan(err_orphan), .err_overflow(err_overflow)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; ooo_mode = mode;
    iss_valid = 0; rsp_valid = 0; cmp_ready = 0; reg_wr_ready = 1; req_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present a request for one cycle; report the sampled iss_ready.
  task automatic issue(input int seq, input logic [1:0] kind, output logic rdy);
    @(negedge clk);
    iss_valid = 1; iss_seq = SEQ_W'(seq); iss_kind = kind;
    #1 rdy = iss_ready;
    @(posedge clk);
    #1 iss_valid = 0;
  endtask

  task automatic respond(input int seq, input logic [1:0] kind, input int lat,
                         output logic orph, output logic ovf);
    @(negedge clk);
    rsp_valid = 1; rsp_seq = SEQ_W'(seq); rsp_kind = kind; rsp_lat = LAT_W'(lat);
    #1 begin orph = err_orphan; ovf = err_overflow; end
    @(posedge clk);
    #1 rsp_valid = 0;
  endtask

  task automatic take(input string r, input int seq, input logic [1:0] kind);
    @(negedge clk);
    cmp_ready = 1;
    #1;
    chk(r, int'(cmp_valid), 1);
    chk(r, int'(cmp_seq), seq);
    chk(r, int'(cmp_kind), int'(kind));
    @(posedge clk);
    #1 cmp_ready = 0;
  endtask

  task automatic peek_idle(input string r);
    @(negedge clk);
    #1 chk(r, int'(cmp_valid), 0);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    #1;
    chk("R11 iss_ready", int'(iss_ready), 1);
    chk("R11 cmp_valid", int'(cmp_valid), 0);
    chk("R11 errors", int'({err_orphan, err_overflow}), 0);
    req_ready = 0;
    #1 chk("R11 iss_ready follows req_ready", int'(iss_ready), 0);
    req_ready = 1;
  endtask

  task automatic t_ordered;
    logic r, o, v;
    do_reset(1'b0);
    issue(0, LD, r); chk("R5 issue 0", int'(r), 1);
    issue(1, LD, r); chk("R5 issue 1", int'(r), 1);
    issue(2, ST, r); chk("R5 issue 2", int'(r), 1);
    respond(2, ST, 0, o, v);
    respond(1, LD, 0, o, v);
    peek_idle("R5 younger done waits");
    respond(0, LD, 0, o, v);
    take("R5 first", 0, LD);
    take("R5 second", 1, LD);
    take("R5 third", 2, ST);
    // R3: fence between loads
    issue(3, LD, r);
    issue(99, FN, r); chk("R3 fence issues", int'(r), 1);
    issue(4, LD, r);
    respond(3, LD, 0, o, v);
    respond(4, LD, 0, o, v);
    take("R3 before fence", 3, LD);
    take("R3 after fence", 4, LD);
    peek_idle("R3 fence gives no completion");
  endtask

  task automatic t_orphan;
    logic o, v;
    do_reset(1'b0);
    respond(50, LD, 0, o, v);
    chk("R4 orphan flagged", int'(o), 1);
    peek_idle("R4 orphan no completion");
  endtask

  task automatic t_credit;
    logic r, o, v;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) begin
      issue(i, LD, r); chk("R1 load within pool", int'(r), 1);
    end
    @(negedge clk);
    iss_valid = 1; iss_seq = 8'd4; iss_kind = AT;
    #1;
    chk("R1 atomic uses load pool", int'(iss_ready), 0);
    chk("R2 req_valid low at cap", int'(req_valid), 0);
    @(posedge clk); #1 iss_valid = 0;
    for (int i = 5; i < 9; i++) begin
      issue(i, ST, r); chk("R1 store independent", int'(r), 1);
    end
    issue(9, ST, r); chk("R1 store pool cap", int'(r), 0);
    issue(10, FN, r); chk("R2 fence ignores credits", int'(r), 1);
    respond(0, LD, 0, o, v);
    take("R10 retire load", 0, LD);
    issue(4, AT, r); chk("R10 credit returned", int'(r), 1);
  endtask

  task automatic t_priority;
    logic r, o, v;
    do_reset(1'b1);
    issue(1, ST, r);
    issue(2, LD, r);
    respond(1, ST, 0, o, v);
    respond(2, LD, 0, o, v);
    reg_wr_ready = 0;
    peek_idle("R6 store held behind blocked load");
    peek_idle("R8 load gated by reg_wr_ready");
    reg_wr_ready = 1;
    take("R6 load first", 2, LD);
    take("R6 store next", 1, ST);
    issue(3, ST, r);
    respond(3, ST, 0, o, v);
    reg_wr_ready = 0;
    take("R8 store ignores reg_wr_ready", 3, ST);
    reg_wr_ready = 1;
  endtask

  task automatic t_latency;
    logic r, o, v;
    do_reset(1'b1);
    issue(4, LD, r);
    issue(5, LD, r);
    respond(4, LD, 3, o, v);
    respond(5, LD, 0, o, v);
    take("R9 first", 4, LD);
    for (int i = 0; i < 3; i++) peek_idle("R9 bus busy");
    take("R9 after gap", 5, LD);
  endtask

  task automatic t_overflow;
    logic o, v;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) begin
      respond(20 + i, ST, 0, o, v);
      chk("R7 no overflow below depth", int'(v), 0);
    end
    respond(30, ST, 0, o, v);
    chk("R7 overflow flagged", int'(v), 1);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ordered();
    t_orphan();
    t_credit();
    t_priority();
    t_latency();
    t_overflow();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule